// File: doc/BRIEF.md
# Indexed Voice Parameter Register Bank

This block holds the per-voice 16-bit parameter words of a wavetable synthesizer. It also holds the active-voice count and a global control byte. The host reaches everything through four byte offsets. Two offsets select a voice and a function code. The other two are data ports, one for the low byte or the whole word and one for the high byte. A write to a data port is steered by the current function code to one of three places: a voice parameter word, the voice-count register or the control byte. A read through a data port returns a parameter word, one byte of it, the voice count, or an all-ones pattern for codes it does not recognise.

Parameters are written with codes 0x00 to 0x0D and read back with codes 0x80 to 0x8D. The low nibble of the code names the parameter in both directions. Byte writes merge into the stored word and leave the other byte alone. Bit 0 of the control byte acts as a run flag: while it is clear, parameter writes are dropped. Clearing it also reloads the voice count with 0xCD. The parameter words live in a byte-lane RAM with a registered read, so read data appears two cycles after the read strobe.

Top module: `voice_regbank`

## Requirements
- R1: Offset 0 is the voice select and offset 1 is the function select. A write stores wdata[7:0]. A read returns the stored byte zero-extended to 16 bits.
- R2: A parameter word is addressed by the low 5 bits of the voice select and the low nibble of the function code. Write codes 0x00–0x0D and read codes 0x80–0x8D reach the same word. Voice-select bits above bit 4 are ignored, and each voice and parameter is stored separately.
- R3: A byte write (byte_mode=1) at offset 2 replaces bits 7:0 of the addressed word with wdata[7:0] and keeps bits 15:8.
- R4: A byte write at offset 3 puts wdata[7:0] into bits 15:8 of the addressed word and keeps bits 7:0.
- R5: A word access (byte_mode=0) at offset 2 or 3 writes or returns all 16 bits.
- R6: A byte read at offset 2 returns {8'h00, word[7:0]}. A byte read at offset 3 returns {8'h00, word[15:8]}.
- R7: A data-port write with code 0x4C loads the control byte from wdata[7:0]. While control bit 0 is 0, parameter writes are ignored. Reset clears the control byte.
- R8: A data-port write with code 0x0E loads the voice count from wdata[7:0], whatever the control byte holds. A read with code 0x8E returns {8'h00, count}. Reset, and any control write with bit 0 clear, load the count with 0xCD.
- R9: A data-port read with any code other than 0x80–0x8D or 0x8E returns 16'hFFFF. A data-port write with a code other than 0x00–0x0E or 0x4C changes nothing.
- R10: rdata is valid and rvalid is high for exactly one cycle, two clock edges after the edge that samples rd_en. rdata holds its value in every other cycle.
- R11: When rd_en and wr_en are both high in one cycle, both take effect, and the read returns the state from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| port_sel | input | 2 | Offset: 0 voice select, 1 function select, 2 low/word data, 3 high data |
| byte_mode | input | 1 | 1 = byte access, 0 = word access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rvalid | output | 1 | Read data valid pulse |

## Verification
A read and a write can fall in the same cycle, because both strobes share one offset. The bench raises both strobes together in two cases. On the voice-select port, the read must return the old select and a later read must return the new one. On a data port with a write-only parameter code, the read must return all ones while the write still lands in the array, which a later read with the matching read code confirms. Each parameter word is seeded before any read, so a read-first result can be told apart from a write-first one.

// File: rtl/vrb_pkg.sv
package vrb_pkg;

  typedef enum logic [1:0] {
    PORT_VSEL = 2'd0,
    PORT_FSEL = 2'd1,
    PORT_DLO  = 2'd2,
    PORT_DHI  = 2'd3
  } port_e;

  typedef enum logic [2:0] {
    RK_MEM  = 3'd0,
    RK_CNT  = 3'd1,
    RK_VSEL = 3'd2,
    RK_FSEL = 3'd3,
    RK_BAD  = 3'd4
  } rkind_e;

  localparam logic [7:0] FN_CNT_WR  = 8'h0E;
  localparam logic [7:0] FN_CNT_RD  = 8'h8E;
  localparam logic [7:0] FN_CTRL    = 8'h4C;
  localparam logic [3:0] FN_WR_GRP  = 4'h0;
  localparam logic [3:0] FN_RD_GRP  = 4'h8;
  localparam logic [3:0] LAST_PARAM = 4'hD;

endpackage

// File: rtl/vrb_host_regs.sv
module vrb_host_regs #(
  parameter int         SEL_W    = 8,
  parameter logic [7:0] CNT_INIT = 8'hCD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vsel_we,
  input  logic             fsel_we,
  input  logic             ctrl_we,
  input  logic             cnt_we,
  input  logic [SEL_W-1:0] wbyte,
  output logic [SEL_W-1:0] voice_sel,
  output logic [SEL_W-1:0] func_sel,
  output logic [SEL_W-1:0] ctrl,
  output logic [SEL_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      voice_sel <= '0;
      func_sel  <= '0;
      ctrl      <= '0;
      count     <= CNT_INIT;
    end else begin
      if (vsel_we) voice_sel <= wbyte;
      if (fsel_we) func_sel  <= wbyte;
      if (ctrl_we) begin
        ctrl <= wbyte;
        if (!wbyte[0]) count <= CNT_INIT;
      end else if (cnt_we) begin
        count <= wbyte;
      end
    end
  end

  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    ctrl_we && !wbyte[0] |=> count == CNT_INIT); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we && !cnt_we |=> $stable(count)); // R8
  AST_VSEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vsel_we |=> $stable(voice_sel)); // R1

endmodule

// File: rtl/vrb_decode.sv
module vrb_decode
  import vrb_pkg::*;
#(
  parameter int VOICE_BITS = 5,
  parameter int SLOT_BITS  = 4,
  parameter int DW         = 16,
  parameter int SEL_W      = 8,
  localparam int AW        = VOICE_BITS + SLOT_BITS,
  localparam int LANES     = DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [1:0]       port_sel,
  input  logic             byte_mode,
  input  logic [DW-1:0]    wdata,
  input  logic [SEL_W-1:0] voice_sel,
  input  logic [SEL_W-1:0] func_sel,
  input  logic             gate_open,
  output logic             vsel_we,
  output logic             fsel_we,
  output logic             ctrl_we,
  output logic             cnt_we,
  output logic [LANES-1:0] lane_we,
  output logic [DW-1:0]    mem_wdata,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_rd,
  output rkind_e           rd_kind,
  output logic             rd_hi,
  output logic             rd_byte
);

  logic             data_port;
  logic             hi_port;
  logic             wr_param_code;
  logic             rd_param_code;
  logic             param_wr;
  logic [LANES-1:0] lane_mask;

  always_comb begin
    data_port     = port_sel[1];
    hi_port       = (port_sel == PORT_DHI);
    wr_param_code = (func_sel[7:4] == FN_WR_GRP) && (func_sel[3:0] <= LAST_PARAM);
    rd_param_code = (func_sel[7:4] == FN_RD_GRP) && (func_sel[3:0] <= LAST_PARAM);
    mem_addr      = {voice_sel[VOICE_BITS-1:0], func_sel[SLOT_BITS-1:0]};
    param_wr      = wr_en && data_port && wr_param_code && gate_open;
  end

  always_comb begin
    if (!byte_mode)   lane_mask = '1;
    else if (hi_port) lane_mask = LANES'(2);
    else              lane_mask = LANES'(1);
    lane_we   = param_wr ? lane_mask : '0;
    mem_wdata = byte_mode ? {LANES{wdata[7:0]}} : wdata;
  end

  always_comb begin
    vsel_we = wr_en && (port_sel == PORT_VSEL);
    fsel_we = wr_en && (port_sel == PORT_FSEL);
    ctrl_we = wr_en && data_port && (func_sel == FN_CTRL);
    cnt_we  = wr_en && data_port && (func_sel == FN_CNT_WR);
  end

  always_comb begin
    mem_rd  = rd_en && data_port && rd_param_code;
    rd_hi   = hi_port;
    rd_byte = byte_mode;
    unique case (port_sel)
      PORT_VSEL: rd_kind = RK_VSEL;
      PORT_FSEL: rd_kind = RK_FSEL;
      default: begin
        if (rd_param_code)               rd_kind = RK_MEM;
        else if (func_sel == FN_CNT_RD)  rd_kind = RK_CNT;
        else                             rd_kind = RK_BAD;
      end
    endcase
  end

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    byte_mode |-> $onehot0(lane_we)); // R3
  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (rst)
    !gate_open |-> lane_we == '0); // R7
  AST_NO_WR_NO_LANE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> lane_we == '0 && !ctrl_we && !cnt_we); // R9

endmodule

// File: rtl/vrb_bank.sv
module vrb_bank #(
  parameter int AW     = 9,
  parameter int DW     = 16,
  localparam int DEPTH = 1 << AW,
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_q
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] lane_q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[addr] <= wdata[g*8 +: 8];
      if (rd_en)      lane_q    <= mem[addr];
    end

    assign rd_q[g*8 +: 8] = lane_q;
  end

  AST_RDQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q)); // R10

endmodule

// File: rtl/vrb_readout.sv
module vrb_readout
  import vrb_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  rkind_e           rd_kind,
  input  logic             rd_hi,
  input  logic             rd_byte,
  input  logic [DW-1:0]    mem_q,
  input  logic [SEL_W-1:0] voice_sel,
  input  logic [SEL_W-1:0] func_sel,
  input  logic [SEL_W-1:0] count,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);

  logic             s1_valid;
  rkind_e           s1_kind;
  logic             s1_hi;
  logic             s1_byte;
  logic [SEL_W-1:0] s1_aux;
  logic [SEL_W-1:0] aux_next;
  logic [DW-1:0]    out_next;

  always_comb begin
    unique case (rd_kind)
      RK_VSEL: aux_next = voice_sel;
      RK_FSEL: aux_next = func_sel;
      RK_CNT:  aux_next = count;
      default: aux_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_kind  <= RK_BAD;
      s1_hi    <= 1'b0;
      s1_byte  <= 1'b0;
      s1_aux   <= '0;
    end else begin
      s1_valid <= rd_req;
      if (rd_req) begin
        s1_kind <= rd_kind;
        s1_hi   <= rd_hi;
        s1_byte <= rd_byte;
        s1_aux  <= aux_next;
      end
    end
  end

  always_comb begin
    unique case (s1_kind)
      RK_MEM: begin
        if (!s1_byte)   out_next = mem_q;
        else if (s1_hi) out_next = {{(DW-8){1'b0}}, mem_q[15:8]};
        else            out_next = {{(DW-8){1'b0}}, mem_q[7:0]};
      end
      RK_BAD:  out_next = '1;
      default: out_next = {{(DW-SEL_W){1'b0}}, s1_aux};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= s1_valid;
      if (s1_valid) rdata <= out_next;
    end
  end

  AST_RVALID_LAT: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ##2 rvalid); // R10
  AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(rd_req, 2)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> $stable(rdata)); // R10
  AST_BAD_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    s1_valid && s1_kind == RK_BAD |=> rdata == '1); // R9

endmodule

// File: rtl/voice_regbank.sv
module voice_regbank
  import vrb_pkg::*;
#(
  parameter int         VOICE_BITS = 5,
  parameter int         SLOT_BITS  = 4,
  parameter int         DW         = 16,
  parameter logic [7:0] CNT_INIT   = 8'hCD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [1:0]    port_sel,
  input  logic          byte_mode,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  localparam int AW    = VOICE_BITS + SLOT_BITS;
  localparam int LANES = DW / 8;
  localparam int SEL_W = 8;

  logic [SEL_W-1:0] voice_sel;
  logic [SEL_W-1:0] func_sel;
  logic [SEL_W-1:0] ctrl;
  logic [SEL_W-1:0] count;
  logic             vsel_we;
  logic             fsel_we;
  logic             ctrl_we;
  logic             cnt_we;
  logic [LANES-1:0] lane_we;
  logic [DW-1:0]    mem_wdata;
  logic [AW-1:0]    mem_addr;
  logic             mem_rd;
  rkind_e           rd_kind;
  logic             rd_hi;
  logic             rd_byte;
  logic [DW-1:0]    mem_q;

  vrb_host_regs #(.SEL_W(SEL_W), .CNT_INIT(CNT_INIT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .vsel_we   (vsel_we),
    .fsel_we   (fsel_we),
    .ctrl_we   (ctrl_we),
    .cnt_we    (cnt_we),
    .wbyte     (wdata[SEL_W-1:0]),
    .voice_sel (voice_sel),
    .func_sel  (func_sel),
    .ctrl      (ctrl),
    .count     (count)
  );

  vrb_decode #(
    .VOICE_BITS(VOICE_BITS), .SLOT_BITS(SLOT_BITS), .DW(DW), .SEL_W(SEL_W)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .port_sel  (port_sel),
    .byte_mode (byte_mode),
    .wdata     (wdata),
    .voice_sel (voice_sel),
    .func_sel  (func_sel),
    .gate_open (ctrl[0]),
    .vsel_we   (vsel_we),
    .fsel_we   (fsel_we),
    .ctrl_we   (ctrl_we),
    .cnt_we    (cnt_we),
    .lane_we   (lane_we),
    .mem_wdata (mem_wdata),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .rd_kind   (rd_kind),
    .rd_hi     (rd_hi),
    .rd_byte   (rd_byte)
  );

  vrb_bank #(.AW(AW), .DW(DW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (mem_rd),
    .addr    (mem_addr),
    .lane_we (lane_we),
    .wdata   (mem_wdata),
    .rd_q    (mem_q)
  );

  vrb_readout #(.DW(DW), .SEL_W(SEL_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_en),
    .rd_kind   (rd_kind),
    .rd_hi     (rd_hi),
    .rd_byte   (rd_byte),
    .mem_q     (mem_q),
    .voice_sel (voice_sel),
    .func_sel  (func_sel),
    .count     (count),
    .rdata     (rdata),
    .rvalid    (rvalid)
  );

  AST_CTRL_RESET: assert property (@(posedge clk)
    $past(rst) |-> ctrl == '0); // R7

endmodule

// File: tb/sim_voice_regbank.sv
module sim_voice_regbank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  port_sel = 2'd0;
  logic        byte_mode = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        rvalid;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  voice_regbank u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .port_sel(port_sel), .byte_mode(byte_mode), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] p, input logic bm, input logic [15:0] d);
    @(negedge clk);
    port_sel = p; byte_mode = bm; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] p, input logic bm, output logic [15:0] d);
    @(negedge clk);
    port_sel = p; byte_mode = bm; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    check("R10 rvalid", {15'h0, rvalid}, 16'h0001);
    d = rdata;
  endtask

  task automatic rw(input logic [1:0] p, input logic bm, input logic [15:0] dw,
                    output logic [15:0] d);
    @(negedge clk);
    port_sel = p; byte_mode = bm; wdata = dw; rd_en = 1'b1; wr_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic sel(input logic [7:0] v, input logic [7:0] f);
    wr(2'd0, 1'b0, {8'h00, v});
    wr(2'd1, 1'b0, {8'h00, f});
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R10 rvalid idle", {15'h0, rvalid}, 16'h0000);
    rd(2'd0, 1'b0, d); check("R1 vsel after reset", d, 16'h0000);
    wr(2'd1, 1'b0, 16'h008E);
    rd(2'd2, 1'b0, d); check("R8 count after reset", d, 16'h00CD);
  endtask

  task automatic t_gate;
    logic [15:0] d;
    sel(8'h03, 8'h02);
    wr(2'd2, 1'b0, 16'h5555);
    sel(8'h03, 8'h4C); wr(2'd2, 1'b0, 16'h0001);
    sel(8'h03, 8'h02); wr(2'd2, 1'b0, 16'hAAAA);
    sel(8'h03, 8'h0E); wr(2'd2, 1'b0, 16'h0020);
    sel(8'h03, 8'h4C); wr(2'd2, 1'b0, 16'h0000);
    sel(8'h03, 8'h02); wr(2'd2, 1'b0, 16'h1234);
    sel(8'h03, 8'h0E); wr(2'd2, 1'b0, 16'h0011);
    sel(8'h03, 8'h8E); rd(2'd2, 1'b0, d);
    check("R8 count write ungated", d, 16'h0011);
    sel(8'h03, 8'h4C); wr(2'd2, 1'b0, 16'h0000);
    sel(8'h03, 8'h8E); rd(2'd2, 1'b0, d);
    check("R8 control clear reloads CD", d, 16'h00CD);
    sel(8'h03, 8'h4C); wr(2'd2, 1'b0, 16'h0001);
    sel(8'h03, 8'h82); rd(2'd2, 1'b0, d);
    check("R7 closed gate dropped write", d, 16'hAAAA);
  endtask

  task automatic t_word;
    logic [15:0] d;
    sel(8'h00, 8'h00); wr(2'd2, 1'b0, 16'h0F0F);
    sel(8'h1F, 8'h0D); wr(2'd3, 1'b0, 16'hC3A5);
    sel(8'h03, 8'h05); wr(2'd2, 1'b0, 16'hBEEF);
    sel(8'h00, 8'h80); rd(2'd2, 1'b0, d); check("R2 voice0 param0", d, 16'h0F0F);
    sel(8'h1F, 8'h8D); rd(2'd3, 1'b0, d); check("R5 word at high port", d, 16'hC3A5);
    rd(2'd2, 1'b0, d); check("R5 word at low port", d, 16'hC3A5);
    sel(8'hE3, 8'h85); rd(2'd2, 1'b0, d); check("R2 upper voice bits ignored", d, 16'hBEEF);
    repeat (3) @(negedge clk);
    check("R10 rdata holds", rdata, 16'hBEEF);
  endtask

  task automatic t_bytes;
    logic [15:0] d;
    sel(8'h07, 8'h01); wr(2'd2, 1'b0, 16'h1122);
    wr(2'd2, 1'b1, 16'hFF33);
    sel(8'h07, 8'h81); rd(2'd2, 1'b0, d); check("R3 low byte merge", d, 16'h1133);
    sel(8'h07, 8'h01); wr(2'd3, 1'b1, 16'hEE44);
    sel(8'h07, 8'h81); rd(2'd2, 1'b0, d); check("R4 high byte merge", d, 16'h4433);
    rd(2'd2, 1'b1, d); check("R6 low byte read", d, 16'h0033);
    rd(2'd3, 1'b1, d); check("R6 high byte read", d, 16'h0044);
  endtask

  task automatic t_codes;
    logic [15:0] d;
    sel(8'h07, 8'h81); wr(2'd2, 1'b0, 16'h9999);
    rd(2'd2, 1'b0, d); check("R9 write with read code ignored", d, 16'h4433);
    sel(8'h07, 8'h0E); rd(2'd2, 1'b0, d); check("R9 read with code 0E", d, 16'hFFFF);
    sel(8'h07, 8'h4C); rd(2'd3, 1'b1, d); check("R9 read with code 4C", d, 16'hFFFF);
    sel(8'h07, 8'h8F); rd(2'd2, 1'b1, d); check("R9 read with code 8F", d, 16'hFFFF);
    rd(2'd1, 1'b0, d); check("R1 fsel readback", d, 16'h008F);
  endtask

  task automatic t_same_cycle;
    logic [15:0] d;
    wr(2'd0, 1'b0, 16'h0005);
    rw(2'd0, 1'b0, 16'h0009, d); check("R11 vsel read-before-write", d, 16'h0005);
    rd(2'd0, 1'b0, d); check("R11 vsel written", d, 16'h0009);
    sel(8'h09, 8'h03); wr(2'd2, 1'b0, 16'h0101);
    rw(2'd2, 1'b0, 16'h7E7E, d); check("R11 data read with write code", d, 16'hFFFF);
    sel(8'h09, 8'h83); rd(2'd2, 1'b0, d); check("R11 concurrent write landed", d, 16'h7E7E);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gate();
    t_word();
    t_bytes();
    t_codes();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule